// File: doc/BRIEF.md
# Sliding Memory Aperture Decoder

This block sits on a flat register bus as a slave and gives the host a 1 MB view into a much larger external memory. Host offsets 0x700000 to 0x7FFFFF form the aperture. Any access that lands there is sent on to a memory-side request port. Its memory address is the programmed window base plus the distance into the aperture. A single window control register holds the base as an address shifted right by 16 bits, so the window always starts on a 64 KB boundary. Host accesses that hit neither the aperture nor the control register go out on a default request port.

The parameter `LAYOUT` selects one of three control register layouts. Layout 0 places the register at offset 0x1700 and has a two-bit target field. Layouts 1 and 2 place it at offset 0x10FD40, have no target field and use narrower base fields. Requests are issued one cycle after the host presents them. Responses from the memory side and from the default side are returned to the host without delay. Responses that the block produces itself, for the control register and for rejected accesses, come one cycle after the request.

Top module: `aperture_win_dec`

## Requirements
- R1: After reset the window base is zero, no request or response output is valid, and a control register read returns 0.
- R2: A host access with h_addr[23:20] = 4'h7 whose end does not pass 0x800000 produces m_valid in the next cycle. In that cycle m_addr = base*65536 + (h_addr - 0x700000), and m_write, m_size, m_be and m_wdata carry the host's values unchanged.
- R3: The control register is decoded only at offset 0x1700 when LAYOUT = 0, and only at offset 0x10FD40 when LAYOUT is 1 or 2. The other of the two offsets is treated as an ordinary default-path address.
- R4: The base field occupies data bits [23:0] for LAYOUT 0 (memory address bits 39:16), bits [21:0] for LAYOUT 1 (bits 37:16) and bits [22:0] for LAYOUT 2 (bits 38:16). Written bits above the field are ignored and read back as zero. m_addr wraps modulo 2^(field width + 16), and its bits above that width are zero.
- R5: In LAYOUT 0, data bits [25:24] hold the target, and the only accepted encoding is 0 (video memory). A control write with any other target gets an error response and leaves the base unchanged. The target always reads back as 0.
- R6: A control register access must be 4 bytes (h_size = 2). Any other size gets an error response and does not change the base.
- R7: A control register access gets a response one cycle later with h_rvalid = 1 and h_rerr = 0. For a read, h_rdata holds the base field in its low bits and zeros elsewhere.
- R8: An aperture access with (h_addr - 0x700000) + 2^h_size > 0x100000 issues no memory request and gets h_rvalid = 1 with h_rerr = 1 in the next cycle.
- R9: A new base takes effect for an aperture access that the host presents in the cycle right after the control write.
- R10: Any other host access produces d_valid in the next cycle, with d_addr, d_write, d_size, d_be and d_wdata equal to the host's values, and issues no memory request.
- R11: m_rvalid/m_rdata/m_rerr and d_rvalid/d_rdata/d_rerr are passed to h_rvalid/h_rdata/h_rerr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host request strobe |
| h_write | input | 1 | Host write (1) or read (0) |
| h_addr | input | 24 | Host byte offset |
| h_size | input | 2 | Access size, 2^h_size bytes |
| h_be | input | 8 | Host byte enables |
| h_wdata | input | 64 | Host write data |
| h_rvalid | output | 1 | Host response strobe |
| h_rerr | output | 1 | Host response error |
| h_rdata | output | 64 | Host read data |
| m_valid | output | 1 | Memory request strobe |
| m_write | output | 1 | Memory request direction |
| m_addr | output | 40 | Memory byte address |
| m_size | output | 2 | Memory access size |
| m_be | output | 8 | Memory byte enables |
| m_wdata | output | 64 | Memory write data |
| m_rvalid | input | 1 | Memory response strobe |
| m_rerr | input | 1 | Memory response error |
| m_rdata | input | 64 | Memory read data |
| d_valid | output | 1 | Default-path request strobe |
| d_write | output | 1 | Default-path direction |
| d_addr | output | 24 | Default-path offset |
| d_size | output | 2 | Default-path size |
| d_be | output | 8 | Default-path byte enables |
| d_wdata | output | 64 | Default-path write data |
| d_rvalid | input | 1 | Default-path response strobe |
| d_rerr | input | 1 | Default-path response error |
| d_rdata | input | 64 | Default-path read data |

## Verification
The assertions assume that h_valid stays low during reset. They also assume that a memory or default response never arrives in the same cycle as a response the block generates itself, because the host response lines are shared. The stimulus issues one access at a time and waits for its result before the next. Memory and default responses are injected only while the bus is idle. Random control writes clear or keep the target bits with equal chance, and random aperture offsets are steered toward the top of the window so that straddling accesses occur often.

// File: rtl/aperture_win_dec.sv
module aperture_win_dec #(
  parameter int LAYOUT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  input  logic        h_write,
  input  logic [23:0] h_addr,
  input  logic [1:0]  h_size,
  input  logic [7:0]  h_be,
  input  logic [63:0] h_wdata,
  output logic        h_rvalid,
  output logic        h_rerr,
  output logic [63:0] h_rdata,
  output logic        m_valid,
  output logic        m_write,
  output logic [39:0] m_addr,
  output logic [1:0]  m_size,
  output logic [7:0]  m_be,
  output logic [63:0] m_wdata,
  input  logic        m_rvalid,
  input  logic        m_rerr,
  input  logic [63:0] m_rdata,
  output logic        d_valid,
  output logic        d_write,
  output logic [23:0] d_addr,
  output logic [1:0]  d_size,
  output logic [7:0]  d_be,
  output logic [63:0] d_wdata,
  input  logic        d_rvalid,
  input  logic        d_rerr,
  input  logic [63:0] d_rdata
);
  localparam logic [23:0] CTRL_OFF = (LAYOUT == 0) ? 24'h001700 : 24'h10FD40;
  localparam int BASE_W = (LAYOUT == 0) ? 24 : (LAYOUT == 1) ? 22 : 23;
  localparam int MEM_AW = BASE_W + 16;

  logic [BASE_W-1:0] base_q;
  logic              loc_v, loc_err;
  logic [63:0]       loc_data;

  wire hit_ctrl = (h_addr == CTRL_OFF);
  wire hit_ap   = (h_addr[23:20] == 4'h7);
  wire [20:0] ap_end = {1'b0, h_addr[19:0]} + (21'd1 << h_size);
  wire ap_over  = ap_end > 21'h100000;
  wire tgt_bad  = (LAYOUT == 0) && h_write && (h_wdata[25:24] != 2'b00);
  wire ctrl_bad = (h_size != 2'd2) || tgt_bad;
  wire ctrl_wr  = h_valid && hit_ctrl && h_write && !ctrl_bad;
  wire [MEM_AW-1:0] mem_a = {base_q, 16'h0000} + MEM_AW'(h_addr[19:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      m_valid  <= 1'b0;
      d_valid  <= 1'b0;
      loc_v    <= 1'b0;
      loc_err  <= 1'b0;
      loc_data <= '0;
      m_write  <= 1'b0;
      m_addr   <= '0;
      m_size   <= '0;
      m_be     <= '0;
      m_wdata  <= '0;
      d_write  <= 1'b0;
      d_addr   <= '0;
      d_size   <= '0;
      d_be     <= '0;
      d_wdata  <= '0;
    end else begin
      if (ctrl_wr) base_q <= h_wdata[BASE_W-1:0];
      m_valid  <= h_valid && hit_ap && !ap_over;
      d_valid  <= h_valid && !hit_ap && !hit_ctrl;
      loc_v    <= h_valid && (hit_ctrl || (hit_ap && ap_over));
      loc_err  <= hit_ctrl ? ctrl_bad : 1'b1;
      loc_data <= (hit_ctrl && !h_write && !ctrl_bad) ? 64'(base_q) : 64'h0;
      m_write  <= h_write;
      m_addr   <= 40'(mem_a);
      m_size   <= h_size;
      m_be     <= h_be;
      m_wdata  <= h_wdata;
      d_write  <= h_write;
      d_addr   <= h_addr;
      d_size   <= h_size;
      d_be     <= h_be;
      d_wdata  <= h_wdata;
    end
  end

  assign h_rvalid = loc_v || m_rvalid || d_rvalid;
  assign h_rdata  = loc_v ? loc_data : (m_rvalid ? m_rdata : d_rdata);
  assign h_rerr   = loc_v ? loc_err  : (m_rvalid ? m_rerr  : d_rerr);

  // R2
  ap_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && hit_ap && !ap_over |=> m_valid && !d_valid && (m_addr[15:0] == $past(h_addr[15:0])));

  // R8
  straddle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && hit_ap && ap_over |=> h_rvalid && h_rerr && !m_valid);

  // R10
  dflt_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && !hit_ap && !hit_ctrl |=> d_valid && !m_valid && (d_addr == $past(h_addr)));

  // R4
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_valid && hit_ctrl && h_write) |=> $stable(base_q));

  // R5
  tgt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && hit_ctrl && tgt_bad |=> $stable(base_q) && h_rerr);

  // R6
  size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && hit_ctrl && (h_size != 2'd2) |=> $stable(base_q) && h_rvalid && h_rerr);
endmodule

// File: tb/aperture_win_dec_tb_top.sv
`timescale 1ns/1ps
module aperture_win_dec_tb_top;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        h_valid = 0, h_write = 0;
  logic [23:0] h_addr = 0;
  logic [1:0]  h_size = 0;
  logic [7:0]  h_be = 0;
  logic [63:0] h_wdata = 0;
  logic        m_rvalid = 0, m_rerr = 0, d_rvalid = 0, d_rerr = 0;
  logic [63:0] m_rdata = 0, d_rdata = 0;

  logic        hr[3], he[3], mv[3], mw[3], dv[3], dw[3];
  logic [63:0] hd[3], mwd[3], dwd[3];
  logic [39:0] ma[3];
  logic [23:0] da[3];
  logic [1:0]  ms[3], ds[3];
  logic [7:0]  mb[3], db[3];

  aperture_win_dec #(.LAYOUT(0)) dut_i (
    .clk, .rst_n, .h_valid, .h_write, .h_addr, .h_size, .h_be, .h_wdata,
    .h_rvalid(hr[0]), .h_rerr(he[0]), .h_rdata(hd[0]),
    .m_valid(mv[0]), .m_write(mw[0]), .m_addr(ma[0]), .m_size(ms[0]), .m_be(mb[0]), .m_wdata(mwd[0]),
    .m_rvalid, .m_rerr, .m_rdata,
    .d_valid(dv[0]), .d_write(dw[0]), .d_addr(da[0]), .d_size(ds[0]), .d_be(db[0]), .d_wdata(dwd[0]),
    .d_rvalid, .d_rerr, .d_rdata);
  aperture_win_dec #(.LAYOUT(1)) dut_l1_i (
    .clk, .rst_n, .h_valid, .h_write, .h_addr, .h_size, .h_be, .h_wdata,
    .h_rvalid(hr[1]), .h_rerr(he[1]), .h_rdata(hd[1]),
    .m_valid(mv[1]), .m_write(mw[1]), .m_addr(ma[1]), .m_size(ms[1]), .m_be(mb[1]), .m_wdata(mwd[1]),
    .m_rvalid, .m_rerr, .m_rdata,
    .d_valid(dv[1]), .d_write(dw[1]), .d_addr(da[1]), .d_size(ds[1]), .d_be(db[1]), .d_wdata(dwd[1]),
    .d_rvalid, .d_rerr, .d_rdata);
  aperture_win_dec #(.LAYOUT(2)) dut_l2_i (
    .clk, .rst_n, .h_valid, .h_write, .h_addr, .h_size, .h_be, .h_wdata,
    .h_rvalid(hr[2]), .h_rerr(he[2]), .h_rdata(hd[2]),
    .m_valid(mv[2]), .m_write(mw[2]), .m_addr(ma[2]), .m_size(ms[2]), .m_be(mb[2]), .m_wdata(mwd[2]),
    .m_rvalid, .m_rerr, .m_rdata,
    .d_valid(dv[2]), .d_write(dw[2]), .d_addr(da[2]), .d_size(ds[2]), .d_be(db[2]), .d_wdata(dwd[2]),
    .d_rvalid, .d_rerr, .d_rdata);

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [63:0] base_m[3] = '{64'h0, 64'h0, 64'h0};

  function automatic int bw(int l);
    return (l == 0) ? 24 : (l == 1) ? 22 : 23;
  endfunction
  function automatic logic [23:0] coff(int l);
    return (l == 0) ? 24'h001700 : 24'h10FD40;
  endfunction

  task automatic chk(input bit ok, input string tag, input int l, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s layout%0d: actual=%h expected=%h", tag, l, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [23:0] a, input logic [1:0] sz,
                     input logic [63:0] wd, input string tag);
    logic [7:0] be = 8'($urandom);
    @(negedge clk);
    h_valid = 1; h_write = wr; h_addr = a; h_size = sz; h_be = be; h_wdata = wd;
    @(negedge clk);
    h_valid = 0;
    for (int l = 0; l < 3; l++) begin
      string t;
      logic [63:0] msk = (64'd1 << bw(l)) - 1;
      if (a[23:20] == 4'h7) begin
        logic [63:0] off = 64'(a[19:0]);
        if (off + (64'd1 << sz) > 64'h100000) begin
          t = (tag != "") ? tag : "R8";
          chk(!mv[l] && hr[l] && he[l], t, l, {61'b0, mv[l], hr[l], he[l]}, 64'h3);
        end else begin
          logic [63:0] ea = ((base_m[l] << 16) + off) & ((64'd1 << (bw(l) + 16)) - 1);
          t = (tag != "") ? tag : "R2";
          chk(mv[l] && !dv[l] && !hr[l], t, l, {61'b0, mv[l], dv[l], hr[l]}, 64'h4);
          chk(64'(ma[l]) == ea, t, l, 64'(ma[l]), ea);
          chk(mw[l] == wr && ms[l] == sz && mb[l] == be && mwd[l] == wd, t, l, mwd[l], wd);
        end
      end else if (a == coff(l)) begin
        bit tb = (l == 0) && wr && (wd[25:24] != 2'b00);
        bit bad = (sz != 2'd2) || tb;
        t = (tag != "") ? tag : (tb ? "R5" : (sz != 2'd2) ? "R6" : "R7");
        chk(hr[l] && he[l] == bad && !mv[l] && !dv[l], t, l, {62'b0, hr[l], he[l]}, {62'b0, 1'b1, bad});
        if (!wr && !bad) chk(hd[l] == base_m[l], t, l, hd[l], base_m[l]);
        if (wr && !bad) base_m[l] = wd & msk;
      end else begin
        t = (tag != "") ? tag : "R10";
        chk(dv[l] && !mv[l] && !hr[l], t, l, {61'b0, dv[l], mv[l], hr[l]}, 64'h4);
        chk(da[l] == a && dw[l] == wr && ds[l] == sz && db[l] == be && dwd[l] == wd, t, l, 64'(da[l]), 64'(a));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int l = 0; l < 3; l++)
      chk(!mv[l] && !dv[l] && !hr[l], "R1", l, {61'b0, mv[l], dv[l], hr[l]}, 64'h0);
    acc(0, 24'h001700, 2'd2, 64'h0, "R1");
    acc(0, 24'h10FD40, 2'd2, 64'h0, "R1");

    acc(1, 24'h001700, 2'd2, 64'h0000_0000_0000_ABCD, "R3");
    acc(0, 24'h001700, 2'd2, 64'h0, "R3");
    acc(1, 24'h10FD40, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    acc(0, 24'h10FD40, 2'd2, 64'h0, "R4");
    acc(0, 24'h712340, 2'd3, 64'h0, "R4");

    acc(1, 24'h001700, 2'd2, 64'h0000_0000_0000_0123, "R9");
    acc(1, 24'h700010, 2'd2, 64'h1122_3344_5566_7788, "R9");

    acc(1, 24'h001700, 2'd2, 64'h0000_0000_0100_0055, "R5");
    acc(1, 24'h001700, 2'd2, 64'h0000_0000_0300_0000, "R5");
    acc(0, 24'h001700, 2'd2, 64'h0, "R5");
    acc(1, 24'h001700, 2'd3, 64'h0000_0000_0000_0777, "R6");
    acc(0, 24'h10FD40, 2'd0, 64'h0, "R6");
    acc(0, 24'h001700, 2'd2, 64'h0, "R6");

    acc(0, 24'h7FFFFC, 2'd3, 64'h0, "R8");
    acc(0, 24'h7FFFFE, 2'd2, 64'h0, "R8");
    acc(1, 24'h7FFFFC, 2'd2, 64'hDEAD_0000_BEEF_0000, "R2");
    acc(0, 24'h7FFFFF, 2'd0, 64'h0, "R2");

    acc(1, 24'h001700, 2'd2, 64'h0000_0000_00FF_FFFF, "R4");
    acc(1, 24'h10FD40, 2'd2, 64'h0000_0000_00FF_FFFF, "R4");
    acc(0, 24'h7FFFF0, 2'd3, 64'h0, "R4");
    acc(1, 24'h123456, 2'd1, 64'h5A5A, "R10");

    @(negedge clk);
    m_rvalid = 1; m_rerr = 1; m_rdata = 64'hCAFE_F00D_1234_5678;
    #1;
    for (int l = 0; l < 3; l++)
      chk(hr[l] && he[l] && hd[l] == m_rdata, "R11", l, hd[l], m_rdata);
    @(negedge clk);
    m_rvalid = 0; m_rerr = 0;
    d_rvalid = 1; d_rerr = 0; d_rdata = 64'h0BAD_C0DE_0000_0042;
    #1;
    for (int l = 0; l < 3; l++)
      chk(hr[l] && !he[l] && hd[l] == d_rdata, "R11", l, hd[l], d_rdata);
    @(negedge clk);
    d_rvalid = 0;

    for (int i = 0; i < 500; i++) begin
      int r = int'($urandom % 8);
      logic [23:0] a;
      logic [63:0] wd = {$urandom, $urandom};
      bit wr = 1'($urandom);
      if (r == 0) a = 24'h001700;
      else if (r == 1) a = 24'h10FD40;
      else if (r <= 4) a = {4'h7, 20'($urandom)};
      else if (r == 5) a = 24'h7FFFF8 + 24'($urandom % 8);
      else a = 24'($urandom);
      if ((r <= 1) && ($urandom % 2 == 1)) wd[25:24] = 2'b00;
      if ((r <= 1) && ($urandom % 4 != 0)) acc(wr, a, 2'd2, wd, "");
      else acc(wr, a, 2'($urandom), wd, "");
    end
    finish_run();
  end
endmodule